// File: doc/BRIEF.md
# Processor Interrupt Pending and Mask Unit

This block sits beside a processor pipeline and decides when an interrupt is taken. It holds an 8-bit pending vector, one bit per interrupt line numbered 0 to 7. Individual lines are raised or dropped by index through two request ports. A third strobe empties the whole vector. A free-running count register and a writable compare register form an on-core timer. When the two are equal, the timer raises the pending line chosen by a 3-bit select input.

The pipeline sees a single take-interrupt request. The request is high when interrupts are globally enabled, the core is neither in exception level nor in error level, and at least one pending line is also unmasked. The mask uses the same bit alignment as the pending vector. An any-pending flag reports a non-empty vector whatever the mask and gate inputs are. A request whose index is outside 0 to 7 is dropped and reported on an error pulse.

Top module: `irq_pend_unit`

## Requirements
- R1: While reset is held, pending is 0, idx_err is 0, count is 0 and irq_req is 0. The compare register resets to 0.
- R2: A post request with a legal index n (0 to 7) sets pending bit n and leaves the other bits unchanged. The new value is visible after the next rising clock edge.
- R3: A clear request with a legal index n clears only pending bit n, on the next rising edge.
- R4: clr_all empties the pending vector on the next edge. Any set in the same cycle (post or timer) is applied after the wipe and still lands.
- R5: A post or clear request whose 4-bit index is 8 to 15 leaves pending unchanged. idx_err is then high for exactly the following cycle.
- R6: irq_req equals glb_en AND NOT exc_lvl AND NOT err_lvl AND (irq_mask AND pending is nonzero), evaluated combinationally.
- R7: any_pending is high exactly when pending is nonzero, independent of irq_mask, glb_en, exc_lvl and err_lvl.
- R8: count increments by one on every clock edge after reset and wraps at 2^32.
- R9: When count equals the compare register and count is nonzero, pending bit tsel is set. The bit is first visible in the cycle in which count reads compare+2. A zero count never matches.
- R10: A cmp_wr strobe loads cmp_wdata into the compare register and clears pending bit tsel on the same edge.
- R11: When a set (post or timer) and a clear (clear request or compare write) target the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| post_valid | input | 1 | Post request strobe |
| post_index | input | 4 | Line to set |
| clr_valid | input | 1 | Clear request strobe |
| clr_index | input | 4 | Line to clear |
| clr_all | input | 1 | Empty the whole pending vector |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 32 | Compare write value |
| tsel | input | 3 | Pending line driven by the timer |
| irq_mask | input | 8 | Per-line enable mask |
| glb_en | input | 1 | Global interrupt enable |
| exc_lvl | input | 1 | Exception level active |
| err_lvl | input | 1 | Error level active |
| pending | output | 8 | Pending vector |
| any_pending | output | 1 | Pending vector is nonzero |
| irq_req | output | 1 | Take-interrupt request |
| idx_err | output | 1 | Illegal index seen in the previous cycle |
| count | output | 32 | Free-running count |

## Verification
The properties assume that the index fields and tsel are stable and known whenever their strobes are sampled. They also assume that a post, a clear and a compare write aimed at the same line in one cycle are resolved only by the set-wins rule, so several checks exclude those overlaps in their antecedents. The random stimulus keeps every input defined at every edge. It leaves the compare register at zero, so timer hits occur only in the directed timer sequence, where the bench sets the compare a few cycles ahead of the count it reads. Indices are drawn from 0 to 11, so illegal requests appear often without crowding out legal ones.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned SEL_W = $clog2(LINES);
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/irq_idx_dec.sv
module irq_idx_dec
  import irq_pend_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  output line_vec_t        hot,
  output logic             bad
);
  localparam int unsigned IDX_LIM = LINES;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hot[i] = valid && (idx == IDX_W'(i));
  end

  assign bad = valid && (int'(idx) >= int'(IDX_LIM));
endmodule

// File: rtl/irq_tmr.sv
module irq_tmr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             hit_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    cmp_d = cmp_wr ? cmp_wdata : cmp_q;
    hit_d = (cnt_q == cmp_q) && (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      hit   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (cmp_wr) cmp_q <= cmp_d;
      hit   <= hit_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pend_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wipe,
  input  line_vec_t set_vec,
  input  line_vec_t clr_vec,
  input  logic      bad_req,
  output line_vec_t pend,
  output logic      err
);
  line_vec_t pend_q, pend_d, base;
  logic      err_q;

  always_comb begin
    base   = wipe ? '0 : pend_q;
    pend_d = (base & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= bad_req;
    end
  end

  assign pend = pend_q;
  assign err  = err_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pend_pkg::*;
(
  input  line_vec_t mask,
  input  line_vec_t pend,
  input  logic      glb_en,
  input  logic      exc_lvl,
  input  logic      err_lvl,
  output logic      req,
  output logic      any
);
  logic gate_open;

  always_comb begin
    gate_open = glb_en && !exc_lvl && !err_lvl;
    any       = |pend;
    req       = gate_open && (|(mask & pend));
  end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
  import irq_pend_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_valid,
  input  logic [IDX_W-1:0] post_index,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_index,
  input  logic             clr_all,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [SEL_W-1:0] tsel,
  input  logic [LINES-1:0] irq_mask,
  input  logic             glb_en,
  input  logic             exc_lvl,
  input  logic             err_lvl,
  output logic [LINES-1:0] pending,
  output logic             any_pending,
  output logic             irq_req,
  output logic             idx_err,
  output logic [CNT_W-1:0] count
);
  logic      rst_meta_n, rst_q_n;
  line_vec_t post_hot, clr_hot, tsel_hot, set_vec, clr_vec;
  logic      post_bad, clr_bad, tmr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  irq_idx_dec #(.IDX_W(IDX_W)) u_post_dec (
    .valid(post_valid), .idx(post_index), .hot(post_hot), .bad(post_bad)
  );

  irq_idx_dec #(.IDX_W(IDX_W)) u_clr_dec (
    .valid(clr_valid), .idx(clr_index), .hot(clr_hot), .bad(clr_bad)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_tsel
    assign tsel_hot[i] = (tsel == SEL_W'(i));
  end

  irq_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_q_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .count(count), .hit(tmr_hit)
  );

  always_comb begin
    set_vec = post_hot | (tmr_hit ? tsel_hot : '0);
    clr_vec = clr_hot  | (cmp_wr  ? tsel_hot : '0);
  end

  irq_pend_reg u_pend (
    .clk(clk), .rst_n(rst_q_n), .wipe(clr_all), .set_vec(set_vec),
    .clr_vec(clr_vec), .bad_req(post_bad || clr_bad),
    .pend(pending), .err(idx_err)
  );

  irq_gate u_gate (
    .mask(irq_mask), .pend(pending), .glb_en(glb_en), .exc_lvl(exc_lvl),
    .err_lvl(err_lvl), .req(irq_req), .any(any_pending)
  );
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             post_valid,
  input logic [IDX_W-1:0] post_index,
  input logic             clr_valid,
  input logic [IDX_W-1:0] clr_index,
  input logic             clr_all,
  input logic             cmp_wr,
  input logic [SEL_W-1:0] tsel,
  input logic             glb_en,
  input logic             exc_lvl,
  input logic             err_lvl,
  input logic [LINES-1:0] pending,
  input logic             any_pending,
  input logic             irq_req,
  input logic             idx_err,
  input logic [CNT_W-1:0] count,
  input logic             tmr_hit
);
  logic post_ok, clr_ok;
  assign post_ok = post_valid && (int'(post_index) < int'(LINES));
  assign clr_ok  = clr_valid  && (int'(clr_index)  < int'(LINES));

  AST_POST_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    post_ok |=> pending[$past(post_index[SEL_W-1:0])]); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok && !(post_valid && post_index == clr_index) &&
    !(tmr_hit && tsel == clr_index[SEL_W-1:0])
    |=> !pending[$past(clr_index[SEL_W-1:0])]); // R3
  AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all && !post_valid && !tmr_hit |=> pending == '0); // R4
  AST_BAD_IDX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !post_ok) || (clr_valid && !clr_ok) |=> idx_err); // R5
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en || exc_lvl || err_lvl) |-> !irq_req); // R6
  AST_REQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> any_pending); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == $past(count) + CNT_W'(1)); // R8
  AST_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |=> !tmr_hit); // R9
  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr && !tmr_hit && !(post_valid && post_index == IDX_W'(tsel))
    |=> !pending[$past(tsel)]); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    post_ok && clr_valid && clr_index == post_index
    |=> pending[$past(post_index[SEL_W-1:0])]); // R11
endmodule

bind irq_pend_unit irq_pend_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .post_valid(post_valid), .post_index(post_index),
  .clr_valid(clr_valid), .clr_index(clr_index), .clr_all(clr_all),
  .cmp_wr(cmp_wr), .tsel(tsel), .glb_en(glb_en), .exc_lvl(exc_lvl),
  .err_lvl(err_lvl), .pending(pending), .any_pending(any_pending),
  .irq_req(irq_req), .idx_err(idx_err), .count(count), .tmr_hit(tmr_hit)
);

// File: tb/irq_pend_unit_test.sv
`timescale 1ns/1ps
module irq_pend_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        post_valid, clr_valid, clr_all, cmp_wr;
  logic [3:0]  post_index, clr_index;
  logic [31:0] cmp_wdata;
  logic [2:0]  tsel;
  logic [7:0]  irq_mask;
  logic        glb_en, exc_lvl, err_lvl;
  logic [7:0]  pending;
  logic        any_pending, irq_req, idx_err;
  logic [31:0] count;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  logic [7:0]  exp_pend;
  logic        hq;
  logic [31:0] cmp_m;
  logic [31:0] tc;

  always #2.5 clk = ~clk;

  irq_pend_unit uut (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_index(post_index),
    .clr_valid(clr_valid), .clr_index(clr_index), .clr_all(clr_all),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .tsel(tsel), .irq_mask(irq_mask),
    .glb_en(glb_en), .exc_lvl(exc_lvl), .err_lvl(err_lvl), .pending(pending),
    .any_pending(any_pending), .irq_req(irq_req), .idx_err(idx_err), .count(count)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_req(input logic [7:0] p);
    return glb_en && !exc_lvl && !err_lvl && ((irq_mask & p) != 8'h00);
  endfunction

  task automatic idle();
    post_valid = 0; post_index = 0; clr_valid = 0; clr_index = 0;
    clr_all = 0; cmp_wr = 0; cmp_wdata = 0;
  endtask

  task automatic check_outs(input string tag);
    chk(pending == exp_pend, tag, 32'(pending), 32'(exp_pend));
    chk(any_pending == (exp_pend != 0), "R7 any_pending", 32'(any_pending),
        32'(exp_pend != 0));
    chk(irq_req == exp_req(exp_pend), "R6 irq_req", 32'(irq_req),
        32'(exp_req(exp_pend)));
  endtask

  task automatic tick(input string tag);
    logic [7:0]  setv, clrv, nxt;
    logic        e_err, nhq;
    logic [31:0] c;
    c = count;
    setv = 0; clrv = 0;
    if (post_valid && post_index < 8) setv[post_index[2:0]] = 1'b1;
    if (hq) setv[tsel] = 1'b1;
    if (clr_valid && clr_index < 8) clrv[clr_index[2:0]] = 1'b1;
    if (cmp_wr) clrv[tsel] = 1'b1;
    nxt = ((clr_all ? 8'h00 : exp_pend) & ~clrv) | setv;
    e_err = (post_valid && post_index >= 8) || (clr_valid && clr_index >= 8);
    nhq = (c == cmp_m) && (c != 0);
    if (cmp_wr) cmp_m = cmp_wdata;
    @(posedge clk);
    @(negedge clk);
    exp_pend = nxt;
    hq = nhq;
    check_outs(tag);
    chk(idx_err == e_err, "R5 idx_err", 32'(idx_err), 32'(e_err));
    chk(count == c + 1, "R8 count", count, c + 1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    idle();
    tsel = 0; irq_mask = 8'hFF; glb_en = 1; exc_lvl = 0; err_lvl = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(pending == 0, "R1 pending", 32'(pending), 0);
    chk(idx_err == 0, "R1 idx_err", 32'(idx_err), 0);
    chk(count == 0, "R1 count", count, 0);
    chk(irq_req == 0, "R1 irq_req", 32'(irq_req), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    exp_pend = 0; hq = 0; cmp_m = 0;
    chk(pending == 0, "R1 pending after release", 32'(pending), 0);

    // R2 single post
    post_valid = 1; post_index = 5; tick("R2 post 5");
    chk(pending == 8'h20, "R2 only bit 5", 32'(pending), 32'h20);
    idle(); post_valid = 1; post_index = 0; tick("R2 post 0");
    // R3 single clear
    idle(); clr_valid = 1; clr_index = 5; tick("R3 clear 5");
    chk(pending == 8'h01, "R3 only bit 5 dropped", 32'(pending), 32'h01);
    // R11 set wins
    idle(); post_valid = 1; post_index = 7; clr_valid = 1; clr_index = 7;
    tick("R11 set over clear");
    chk(pending[7] == 1'b1, "R11 bit 7", 32'(pending[7]), 1);
    // R4 wipe with post
    idle(); clr_all = 1; post_valid = 1; post_index = 2; tick("R4 wipe+post");
    chk(pending == 8'h04, "R4 post survives wipe", 32'(pending), 32'h04);
    // R5 illegal index
    idle(); post_valid = 1; post_index = 9; tick("R5 bad post");
    chk(pending == 8'h04 && idx_err, "R5 ignored and flagged",
        {23'd0, idx_err, pending}, 32'h104);
    idle(); clr_valid = 1; clr_index = 4'hA; tick("R5 bad clear");
    idle(); tick("R5 pulse ends");
    chk(idx_err == 0, "R5 single pulse", 32'(idx_err), 0);
    // R6 gate
    irq_mask = 8'h04; #1;
    chk(irq_req == 1, "R6 open gate", 32'(irq_req), 1);
    exc_lvl = 1; #1;
    chk(irq_req == 0, "R6 exc level blocks", 32'(irq_req), 0);
    exc_lvl = 0; err_lvl = 1; #1;
    chk(irq_req == 0, "R6 err level blocks", 32'(irq_req), 0);
    err_lvl = 0; glb_en = 0; #1;
    chk(irq_req == 0, "R6 global enable off", 32'(irq_req), 0);
    irq_mask = 8'h00; #1;
    chk(any_pending == 1, "R7 flag ignores mask", 32'(any_pending), 1);
    glb_en = 1; irq_mask = 8'hFF;

    // R10 compare write clears tsel line; R9 timer hit timing
    @(negedge clk);
    tsel = 3;
    idle(); post_valid = 1; post_index = 3; tick("R2 post 3");
    idle(); cmp_wr = 1; cmp_wdata = count + 32'd6; tc = cmp_wdata;
    tick("R10 compare write");
    chk(pending[3] == 0, "R10 tsel line cleared", 32'(pending[3]), 0);
    idle();
    for (int k = 0; k < 20 && count != tc + 1; k++) tick("R9 wait");
    chk(pending[3] == 0, "R9 not yet at compare+1", 32'(pending[3]), 0);
    tick("R9 hit");
    chk(count == tc + 2 && pending[3] == 1, "R9 line set at compare+2",
        32'(pending[3]), 1);

    // random phase
    idle(); clr_all = 1; tick("R4 wipe");
    for (int i = 0; i < 3000; i++) begin
      post_valid = ($urandom_range(0, 2) == 0);
      post_index = 4'($urandom_range(0, 11));
      clr_valid  = ($urandom_range(0, 2) == 0);
      clr_index  = 4'($urandom_range(0, 11));
      clr_all    = ($urandom_range(0, 15) == 0);
      cmp_wr     = ($urandom_range(0, 7) == 0);
      cmp_wdata  = 0;
      tsel       = 3'($urandom_range(0, 7));
      irq_mask   = 8'($urandom);
      glb_en     = ($urandom_range(0, 3) != 0);
      exc_lvl    = ($urandom_range(0, 3) == 0);
      err_lvl    = ($urandom_range(0, 3) == 0);
      tick("R2 R3 R4 R10 R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule